// File: doc/BRIEF.md
# 16-bit Reload Timer with Pulse Output, Event Counting and Capture

This block is a 16-bit down-counter. It reloads itself from a latch and is reached through an 8-bit register port. The count source depends on the mode. In timer mode and pulse output mode it is a prescaled system clock. In event counter mode it is the selected edge of an external pin.

A fourth mode measures the external signal. The counter runs from the prescaled clock. On each selected pin edge the current count is captured into a readable register and the counter restarts from the latch.

The 16-bit value is moved as two bytes. A low-byte write is held in a buffer until the high byte arrives. Reading the high byte freezes the matching low byte for the next low-byte read. Two one-cycle request pulses, one for underflow and one for pin edges, go to an interrupt controller outside the block.

Top module: `tmr16_timer`

## Requirements
- R1: After the synchronous active-low reset, `pulse_out`, `irq_underflow` and `irq_pin_edge` are 0. The counter, latch, capture, both byte buffers and the control register are 0, so reads of address 0, 1 and 2 return 0.
- R2: Control register (address 2) layout:
  - bits [1:0] select the mode: 0 timer, 1 pulse output, 2 event counter, 3 measurement.
  - bits [3:2] select the prescale divisor: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64.
  - bit 7 reads as 0.
  
  In modes 0, 1 and 3 the counter decrements by one on each prescaler tick. With divisor D, ticks fall on every D-th clock counted from reset.
- R3: A count pulse while the counter holds 0 reloads it from the latch instead of decrementing. The same edge raises `irq_underflow` for exactly one cycle.
- R4: While control bit 4 (stop) is 1, the counter neither counts nor captures. It changes only through a bus write.
- R5: A write to address 0 only fills a low-byte buffer. A write to address 1 forms {data, low buffer}. If control bit 6 is 0, that value goes to both the latch and the counter in one cycle. If bit 6 is 1, it goes to the latch only. A bus load of the counter takes precedence over counting in that cycle.
- R6: Address 1 reads the high byte of the visible value. That value is the counter in modes 0 to 2 and the capture register in mode 3. A read of address 1 copies the low byte of the same value into a read buffer. Address 0 returns that read buffer, however much time passes between the two reads. Address 3 reads 0.
- R7: In mode 1, `pulse_out` toggles on every underflow. In the other modes it holds its level.
- R8: In mode 2, each selected edge of `ext_pin` is a count pulse. Control bit 5 selects the edge: 0 for rising, 1 for falling.
- R9: In mode 3 with stop clear, a selected pin edge copies the counter into the capture register and reloads the counter from the latch. Prescaler ticks in that cycle are ignored.
- R10: In every mode, a selected edge of `ext_pin` raises `irq_pin_edge` for one cycle. The pulse starts at the third rising clock edge that samples the new pin level, because the pin passes through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, updates the read buffer on a high-byte read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| ext_pin | input | 1 | External pin, asynchronous |
| pulse_out | output | 1 | Toggle output for pulse output mode |
| irq_underflow | output | 1 | One-cycle underflow request |
| irq_pin_edge | output | 1 | One-cycle selected-edge request |

## Verification
The assertions rely on three things about the environment:
- The edge-select bit changes only while `ext_pin` has been stable long enough to settle in the synchronizer, so a change of polarity cannot produce back-to-back edge pulses.
- Each bus access lasts one cycle.
- Reads and writes are never interleaved between the two halves of a 16-bit access.

The stimulus keeps to these rules by construction. Every control write that flips the edge sense is issued while the pin rests low. Every access goes through one-cycle write and read tasks that complete the low/high pair before anything else touches the bus.

// File: rtl/tmr16_pkg.sv
// Shared types for the 16-bit reload timer.
// Assumes: control register is 7 bits wide, field order fixed by software view.
package tmr16_pkg;

    localparam int PSEL_W = 2;

    typedef enum logic [1:0] {
        M_TIMER = 2'd0,
        M_PULSE = 2'd1,
        M_EVENT = 2'd2,
        M_MEAS  = 2'd3
    } mode_e;

    typedef struct packed {
        logic              lonly;   // bit 6: write high byte to latch only
        logic              fall;    // bit 5: falling edge selected
        logic              stop;    // bit 4: halt counting
        logic [PSEL_W-1:0] psel;    // bits 3:2: prescale select
        mode_e             mode;    // bits 1:0: operating mode
    } ctrl_t;

    localparam logic [1:0] A_LO   = 2'd0;
    localparam logic [1:0] A_HI   = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;

endpackage

// File: rtl/tmr16_prescaler.sv
// Free-running prescaler producing a one-cycle tick every 2**(BASE_LOG+sel) clocks.
// Assumes: counter width covers the largest divisor so every divisor divides its period.
module tmr16_prescaler #(
    parameter int SEL_W    = 2,
    parameter int BASE_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = BASE_LOG + (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;

    // Derive the tick from the low bits of the free-running count.
    always_comb begin
        span = (PRE_W+1)'(1) << (BASE_LOG + int'(sel));
        mask = PRE_W'(span - 1'b1);
        tick = (pre_q & mask) == mask;
    end

    // Advance the prescale count every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/tmr16_edge_sync.sv
// Synchronizes an asynchronous pin and flags its selected edge for one cycle.
// Assumes: STAGES >= 2; polarity changes only while the pin is settled.
module tmr16_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_p
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Shift the pin through one synchronizer stage.
        always_ff @(posedge clk) begin
            if (!rst_n)      sync_q[i] <= 1'b0;
            else if (i == 0) sync_q[i] <= pin;
            else             sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
        end
    end

    // Remember the last synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Compare the current and previous levels against the selected polarity.
    always_comb begin
        edge_p = fall_sel ? (prev_q & ~sync_q[STAGES-1])
                          : (~prev_q & sync_q[STAGES-1]);
    end
endmodule

// File: rtl/tmr16_core.sv
// Counter, reload latch, capture register and pulse toggle of the timer.
// Assumes: load_en is a one-cycle strobe; tick and edge_p are one-cycle pulses.
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic             stop,
    input  logic             tick,
    input  logic             edge_p,
    input  logic             load_en,
    input  logic             latch_only,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] latch_q,
    output logic [CNT_W-1:0] cap_q,
    output logic             irq_uf_q,
    output logic             pulse_q
);
    logic load_cnt, meas_hit, count_en, uf;

    // Resolve the precedence of bus load, measurement restart and counting.
    always_comb begin
        load_cnt = load_en && !latch_only;
        meas_hit = (mode == M_MEAS) && edge_p && !stop;
        count_en = !stop && !meas_hit && ((mode == M_EVENT) ? edge_p : tick);
        uf       = count_en && (cnt_q == '0) && !load_cnt;
    end

    // Update the running count.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_cnt)      cnt_q <= load_val;
        else if (meas_hit)      cnt_q <= latch_q;
        else if (count_en)      cnt_q <= (cnt_q == '0) ? latch_q : cnt_q - 1'b1;
    end

    // Hold the reload value written by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (load_en) latch_q <= load_val;
    end

    // Capture the count on a measurement edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_q <= '0;
        else if (meas_hit) cap_q <= cnt_q;
    end

    // Register the underflow request and the pulse-mode toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_uf_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            irq_uf_q <= uf;
            pulse_q  <= pulse_q ^ (uf && (mode == M_PULSE));
        end
    end
endmodule

// File: rtl/tmr16_timer.sv
// Top of the 16-bit reload timer: byte-wide register port, byte buffers,
// control register and the instances of prescaler, edge sync and core.
// Assumes: one-cycle bus strobes; high byte read before low, low byte written before high.
module tmr16_timer
    import tmr16_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BASE_LOG    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_pin,
    output logic              pulse_out,
    output logic              irq_underflow,
    output logic              irq_pin_edge
);
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] wbuf_q, rbuf_q;
    logic [CNT_W-1:0]  cnt_q, latch_q, cap_q, view;
    logic              tick, edge_p, wr_hi, wr_cnt, edge_irq_q;
    mode_e             cur_mode;
    logic              cur_stop;

    assign cur_mode = ctrl_q.mode;
    assign cur_stop = ctrl_q.stop;

    // Decode the high-byte write and the readable 16-bit value.
    always_comb begin
        wr_hi  = bus_wr && (bus_addr == A_HI);
        wr_cnt = wr_hi && !ctrl_q.lonly;
        view   = (ctrl_q.mode == M_MEAS) ? cap_q : cnt_q;
    end

    // Capture control writes and the pending low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            wbuf_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (bus_addr == A_LO)   wbuf_q <= bus_wdata;
        end
    end

    // Freeze the low byte when the high byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rbuf_q <= '0;
        else if (bus_rd && bus_addr == A_HI) rbuf_q <= view[BYTE_W-1:0];
    end

    // Register the pin-edge request.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_irq_q <= 1'b0;
        else        edge_irq_q <= edge_p;
    end

    // Select read data by address.
    always_comb begin
        unique case (bus_addr)
            A_LO:    bus_rdata = rbuf_q;
            A_HI:    bus_rdata = view[CNT_W-1:BYTE_W];
            A_CTRL:  bus_rdata = BYTE_W'(ctrl_q);
            default: bus_rdata = '0;
        endcase
    end

    tmr16_prescaler #(.SEL_W(PSEL_W), .BASE_LOG(BASE_LOG)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ctrl_q.psel),
        .tick  (tick)
    );

    tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .fall_sel (ctrl_q.fall),
        .edge_p   (edge_p)
    );

    tmr16_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (ctrl_q.mode),
        .stop       (ctrl_q.stop),
        .tick       (tick),
        .edge_p     (edge_p),
        .load_en    (wr_hi),
        .latch_only (ctrl_q.lonly),
        .load_val   ({bus_wdata, wbuf_q}),
        .cnt_q      (cnt_q),
        .latch_q    (latch_q),
        .cap_q      (cap_q),
        .irq_uf_q   (irq_underflow),
        .pulse_q    (pulse_out)
    );

    assign irq_pin_edge = edge_irq_q;
endmodule

// File: rtl/tmr16_timer_chk.sv
// Assertion checker for the reload timer, bound to the top module.
// Assumes: edge polarity changes only while the pin is settled.
module tmr16_timer_chk
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_cnt,
    input mode_e            cur_mode,
    input logic             cur_stop,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] latch_q,
    input logic             irq_underflow,
    input logic             irq_pin_edge,
    input logic             pulse_out
);
    // R2: without a load, a change from a nonzero value is a decrement by one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q) && $past(cnt_q) != '0 && !$past(wr_cnt) && $past(cur_mode) != M_MEAS)
        |-> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

    // R3: leaving zero without a bus load means the latch value was taken
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == '0 && cnt_q != '0 && !$past(wr_cnt)) |-> cnt_q == $past(latch_q));

    // R3: underflow request lasts a single cycle
    p_uf_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_underflow |=> !irq_underflow);

    // R4: stop freezes the counter unless the bus loads it
    p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_stop) && !$past(wr_cnt)) |-> $stable(cnt_q));

    // R7: the output pin moves only together with an underflow
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pulse_out) |-> irq_underflow);

    // R10: pin-edge request lasts a single cycle
    p_edge_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin_edge |=> !irq_pin_edge);
endmodule

bind tmr16_timer tmr16_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_cnt        (wr_cnt),
    .cur_mode      (cur_mode),
    .cur_stop      (cur_stop),
    .cnt_q         (cnt_q),
    .latch_q       (latch_q),
    .irq_underflow (irq_underflow),
    .irq_pin_edge  (irq_pin_edge),
    .pulse_out     (pulse_out)
);

// File: tb/tmr16_timer_tb.sv
module tmr16_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ext = 1'b0;
    logic       pout, iuf, iedge;

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #4 clk = ~clk;  // 125 MHz

    tmr16_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_en), .bus_rd(rd_en),
        .bus_wdata(wdata), .bus_rdata(rdata), .ext_pin(ext),
        .pulse_out(pout), .irq_underflow(iuf), .irq_pin_edge(iedge)
    );

    // behavioural reference state
    logic [15:0] m_cnt, m_lat, m_cap;
    logic [6:0]  m_ctrl;
    logic [7:0]  m_wbuf, m_rbuf;
    logic        m_pout, m_iuf, m_iedge, s1, s2, s3;
    int          pc;

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic [7:0] m_rd(input logic [1:0] a);
        logic [15:0] v;
        v = (m_ctrl[1:0] == 2'd3) ? m_cap : m_cnt;
        case (a)
            2'd0:    return m_rbuf;
            2'd1:    return v[15:8];
            2'd2:    return {1'b0, m_ctrl};
            default: return 8'd0;
        endcase
    endfunction

    // reference model step and per-cycle comparison
    always @(posedge clk) begin : mdl
        int div;
        bit tk, eg, mh, pls, whi, wc, uf, stp;
        logic [1:0] md;
        logic [15:0] nv, old_cnt, old_lat, vw;
        if (!rst_n) begin
            m_cnt = 0; m_lat = 0; m_cap = 0; m_ctrl = 0; m_wbuf = 0; m_rbuf = 0;
            m_pout = 0; m_iuf = 0; m_iedge = 0; s1 = 0; s2 = 0; s3 = 0; pc = 0;
        end else begin
            md  = m_ctrl[1:0];
            stp = m_ctrl[4];
            div = 8 << m_ctrl[3:2];
            tk  = (pc % div) == div - 1;
            eg  = m_ctrl[5] ? (s3 && !s2) : (!s3 && s2);
            whi = wr_en && addr == 2'd1;
            wc  = whi && !m_ctrl[6];
            nv  = {wdata, m_wbuf};
            mh  = md == 2'd3 && eg && !stp;
            pls = !stp && !mh && ((md == 2'd2) ? eg : tk);
            uf  = pls && m_cnt == 0 && !wc;
            old_cnt = m_cnt; old_lat = m_lat;
            vw  = (md == 2'd3) ? m_cap : m_cnt;
            if (rd_en && addr == 2'd1) m_rbuf = vw[7:0];
            if (mh) m_cap = old_cnt;
            if (wc)       m_cnt = nv;
            else if (mh)  m_cnt = old_lat;
            else if (pls) m_cnt = (old_cnt == 0) ? old_lat : old_cnt - 16'd1;
            if (whi) m_lat = nv;
            if (wr_en && addr == 2'd0) m_wbuf = wdata;
            if (wr_en && addr == 2'd2) m_ctrl = wdata[6:0];
            m_pout  = m_pout ^ (uf && md == 2'd1);
            m_iuf   = uf;
            m_iedge = eg;
            s3 = s2; s2 = s1; s1 = ext;
            pc = (pc + 1) % 64;
        end
        #2;
        chk("pulse_out", pout, m_pout);
        chk("irq_underflow", iuf, m_iuf);
        chk("irq_pin_edge", iedge, m_iedge);
        chk("bus_rdata", rdata, m_rd(addr));
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd16();
        rd(2'd1); rd(2'd0);
    endtask

    task automatic toggle(input int n, input int hold);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext = ~ext;
            idle(hold);
        end
    endtask

    initial begin
        // R1: reset values on outputs and all readable registers
        idle(5); rst_n = 1'b1;
        rd(2'd2); rd16(); rd(2'd3);
        // R5: buffered 16-bit write to latch and counter, then latch only
        tag = "R5";
        wr(2'd2, 8'h10); wr(2'd0, 8'h23); wr(2'd1, 8'h01); rd16(); rd(2'd2);
        wr(2'd2, 8'h50); wr(2'd0, 8'h05); wr(2'd1, 8'h00); rd16();
        // R4: stop holds the count
        tag = "R4";
        idle(40); rd16();
        // R2: each prescale divisor in timer mode
        tag = "R2";
        wr(2'd2, 8'h00); idle(60); rd16();
        wr(2'd2, 8'h04); idle(80); rd16();
        wr(2'd2, 8'h08); idle(120); rd16();
        wr(2'd2, 8'h0C); idle(200); rd16();
        // R3: short reload period, underflow pulses
        tag = "R3";
        wr(2'd2, 8'h10); wr(2'd0, 8'h03); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        idle(100); rd16();
        // R6: buffered low byte survives a long gap
        tag = "R6";
        wr(2'd0, 8'hC4); wr(2'd1, 8'h7B); rd(2'd1); idle(30); rd(2'd0); rd(2'd0);
        // R7: pulse output mode toggles on underflow
        tag = "R7";
        wr(2'd0, 8'h02); wr(2'd1, 8'h00); wr(2'd2, 8'h01); idle(200);
        wr(2'd2, 8'h00); idle(60);
        // R8: event counting on rising then falling edges
        tag = "R8";
        wr(2'd0, 8'h04); wr(2'd1, 8'h00); wr(2'd2, 8'h02);
        toggle(20, 5); rd16();
        wr(2'd2, 8'h22); toggle(20, 5); rd16();
        wr(2'd2, 8'h02); wr(2'd0, 8'h00); wr(2'd1, 8'h00); toggle(12, 2); rd16();
        // R9: measurement captures the count at each selected edge
        tag = "R9";
        wr(2'd2, 8'h13); wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'h03);
        for (int k = 0; k < 5; k++) begin
            toggle(1, 40); rd16(); toggle(1, 40); rd16();
        end
        wr(2'd2, 8'h27);
        for (int k = 0; k < 4; k++) begin
            toggle(1, 90); rd16(); toggle(1, 90); rd16();
        end
        wr(2'd2, 8'h33); toggle(2, 30); rd16();
        // R10: pin-edge request in timer mode for both polarities
        tag = "R10";
        wr(2'd2, 8'h00); toggle(6, 7);
        wr(2'd2, 8'h20); toggle(6, 7);
        idle(10);
        done = 1'b1;
        summary();
    end
endmodule